// File: doc/BRIEF.md
# Key-Gated Select Register Guard

This block protects an 8-bit function-select register against accidental change. Software reaches it over a simple register bus: write strobe, read strobe, byte address and 32-bit data. A lock flag starts set. While it is set, the commit mask cannot be changed. Writing a fixed 32-bit key to the lock address clears the flag, and writing any other value there sets it again.

The commit mask is a per-bit write enable for the select register. A write to the select register changes only the bits whose commit bit is one. All other bits keep their old value. A typical sequence is: unlock, program the commit mask, relock, and then update the select register as often as needed. The select register and the lock flag are brought out as ports for the pin multiplexer next to the block.

Top module: `keyed_select_guard`

## Requirements
- R1: Reset sets the lock flag to 1, the commit mask to 0xFF, the select register to 0x00 and the read data to 0.
- R2: A write of exactly 0x0ACCE551 to byte address 0x520 clears the lock flag from the next cycle.
- R3: A write of any other value to address 0x520 sets the lock flag. This includes values that differ from the key in only one bit.
- R4: A write to the commit address 0x524 while the lock flag is set leaves the commit mask unchanged.
- R5: A write to address 0x524 while the lock flag is clear loads data bits 7:0 into the commit mask.
- R6: A write to the select address 0x420 sets each select bit to the new data bit where the commit mask bit is 1. Where the mask bit is 0, the select bit keeps its old value. A mask of 0x00 therefore freezes the register.
- R7: Writing the key changes only the lock flag. The commit mask and the select register keep their values.
- R8: A read strobe returns, one cycle later on the read data port, a zero-extended value: address 0x520 gives the lock flag, 0x524 the commit mask, 0x420 the select register, and any other address 0. Between reads the read data holds its value.
- R9: The lock flag changes only on a write to 0x520. It never relocks by itself after any number of idle cycles.
- R10: A write to an address other than 0x520, 0x524 or 0x420 changes no register. This holds even when the data equals the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rdEn |
| selOut | output | 8 | Current select register |
| lockedOut | output | 1 | Lock flag, 1 while locked |

## Verification
The select register is written under three masks: all ones, a low nibble, and all zeros. These three cases separate a correct per-bit merge from a full overwrite, from an inverted mask and from a frozen register. Lock writes use the exact key, a value one bit away from the key, and zero. This shows that only an exact match unlocks. The key is also sent to the commit address and to an unmapped address, which shows that the address decode takes part in unlocking. Commit writes are made both locked and unlocked, and each result is read back over the bus.

// File: rtl/guard_pkg.sv
package guard_pkg;

  // Strobes from the decoder to the register file
  typedef struct packed {
    logic wrLock;
    logic wrCommit;
    logic wrSelect;
    logic rdLock;
    logic rdCommit;
    logic rdSelect;
    logic rdAny;
  } guard_strobe_t;

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 12'h524,
  parameter logic [ADDR_W-1:0] SELECT_ADDR = 12'h420
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output guard_strobe_t     strobes
);

  logic hitLock;
  logic hitCommit;
  logic hitSelect;

  always_comb begin
    hitLock   = (addr == LOCK_ADDR);
    hitCommit = (addr == COMMIT_ADDR);
    hitSelect = (addr == SELECT_ADDR);

    strobes.wrLock   = wrEn & hitLock;
    strobes.wrCommit = wrEn & hitCommit;
    strobes.wrSelect = wrEn & hitSelect;
    strobes.rdLock   = rdEn & hitLock;
    strobes.rdCommit = rdEn & hitCommit;
    strobes.rdSelect = rdEn & hitSelect;
    strobes.rdAny    = rdEn;
  end

endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import guard_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  guard_strobe_t     strobes,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [REG_W-1:0]  selQ,
  output logic [REG_W-1:0]  commitQ,
  output logic              lockQ
);

  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0] newBits;
  logic [REG_W-1:0] selNext;
  logic             keyMatch;
  logic [DATA_W-1:0] readMux;

  assign newBits  = wdata[REG_W-1:0];
  assign keyMatch = (wdata == UNLOCK_KEY);

  // Per-bit merge: committed bits take new data, the rest keep old
  for (genvar b = 0; b < REG_W; b++) begin : g_merge
    assign selNext[b] = commitQ[b] ? newBits[b] : selQ[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b1;
    end else if (strobes.wrLock) begin
      lockQ <= !keyMatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitQ <= '1;
    end else if (strobes.wrCommit && !lockQ) begin
      commitQ <= newBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (strobes.wrSelect) begin
      selQ <= selNext;
    end
  end

  always_comb begin
    readMux = '0;
    if (strobes.rdLock) begin
      readMux = {{(DATA_W-1){1'b0}}, lockQ};
    end else if (strobes.rdCommit) begin
      readMux = {{PAD_W{1'b0}}, commitQ};
    end else if (strobes.rdSelect) begin
      readMux = {{PAD_W{1'b0}}, selQ};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata <= '0;
    end else if (strobes.rdAny) begin
      rdata <= readMux;
    end
  end

endmodule

// File: rtl/keyed_select_guard.sv
module keyed_select_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 12'h524,
  parameter logic [ADDR_W-1:0] SELECT_ADDR = 12'h420,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [REG_W-1:0]  selOut,
  output logic              lockedOut
);

  guard_strobe_t    strobes;
  logic [REG_W-1:0] commitMaskQ;

  guard_ctrl #(
    .ADDR_W(ADDR_W),
    .LOCK_ADDR(LOCK_ADDR),
    .COMMIT_ADDR(COMMIT_ADDR),
    .SELECT_ADDR(SELECT_ADDR)
  ) uCtrl (
    .wrEn(wrEn),
    .rdEn(rdEn),
    .addr(addr),
    .strobes(strobes)
  );

  guard_dp #(
    .DATA_W(DATA_W),
    .REG_W(REG_W),
    .UNLOCK_KEY(UNLOCK_KEY)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .wdata(wdata),
    .rdata(rdata),
    .selQ(selOut),
    .commitQ(commitMaskQ),
    .lockQ(lockedOut)
  );

endmodule

// File: rtl/keyed_select_guard_chk.sv
module keyed_select_guard_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR   = 12'h520,
  parameter logic [ADDR_W-1:0] COMMIT_ADDR = 12'h524,
  parameter logic [ADDR_W-1:0] SELECT_ADDR = 12'h420,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h0ACC_E551
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [REG_W-1:0]  selOut,
  input logic [REG_W-1:0]  commitMask,
  input logic              lockedOut
);

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == LOCK_ADDR && wdata == UNLOCK_KEY) |=> !lockedOut);

  a_r3_other_value_locks: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == LOCK_ADDR && wdata != UNLOCK_KEY) |=> lockedOut);

  a_r4_locked_commit_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == COMMIT_ADDR && lockedOut) |=> $stable(commitMask));

  a_r6_uncommitted_bits_kept: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == SELECT_ADDR)
      |=> (((selOut ^ $past(selOut)) & ~$past(commitMask)) == '0));

  a_r7_key_keeps_select: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == LOCK_ADDR) |=> ($stable(selOut) && $stable(commitMask)));

  a_r9_lock_only_by_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == LOCK_ADDR) |=> $stable(lockedOut));

endmodule

bind keyed_select_guard keyed_select_guard_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .REG_W(REG_W),
  .LOCK_ADDR(LOCK_ADDR),
  .COMMIT_ADDR(COMMIT_ADDR),
  .SELECT_ADDR(SELECT_ADDR),
  .UNLOCK_KEY(UNLOCK_KEY)
) uChk (
  .clk(clk),
  .rstN(rstN),
  .wrEn(wrEn),
  .addr(addr),
  .wdata(wdata),
  .selOut(selOut),
  .commitMask(commitMaskQ),
  .lockedOut(lockedOut)
);

// File: tb/tb_keyed_select_guard.sv
module tb_keyed_select_guard;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_LOCK   = 12'h520;
  localparam logic [11:0] A_COMMIT = 12'h524;
  localparam logic [11:0] A_SELECT = 12'h420;
  localparam logic [31:0] KEY      = 32'h0ACC_E551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  selOut;
  logic        lockedOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_select_guard dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .selOut(selOut), .lockedOut(lockedOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 lockedOut after reset", {31'b0, lockedOut}, 32'h1);
    check("R1 selOut after reset", {24'b0, selOut}, 32'h0);
    busRead(A_COMMIT, v);
    check("R1 R8 commit read after reset", v, 32'hFF);
    busRead(A_LOCK, v);
    check("R8 lock read while locked", v, 32'h1);
  endtask

  task automatic testFullMask();
    logic [31:0] v;
    busWrite(A_SELECT, 32'hFFFF_FFA5);
    check("R6 select write under full mask", {24'b0, selOut}, 32'hA5);
    busRead(A_SELECT, v);
    check("R8 select read zero-extended", v, 32'hA5);
    repeat (3) @(negedge clk);
    check("R8 rdata holds between reads", rdata, 32'hA5);
  endtask

  task automatic testLockedCommit();
    logic [31:0] v;
    busWrite(A_COMMIT, 32'h0F);
    busRead(A_COMMIT, v);
    check("R4 commit write dropped while locked", v, 32'hFF);
  endtask

  task automatic testUnlock();
    logic [31:0] v;
    busWrite(A_LOCK, KEY ^ 32'h1);
    check("R3 near-key keeps lock", {31'b0, lockedOut}, 32'h1);
    busWrite(A_LOCK, KEY);
    check("R2 key clears lock", {31'b0, lockedOut}, 32'h0);
    busRead(A_LOCK, v);
    check("R8 lock read while unlocked", v, 32'h0);
    check("R7 key leaves select", {24'b0, selOut}, 32'hA5);
    busRead(A_COMMIT, v);
    check("R7 key leaves commit", v, 32'hFF);
    repeat (60) @(negedge clk);
    check("R9 no relock after idle", {31'b0, lockedOut}, 32'h0);
  endtask

  task automatic testPartialMask();
    logic [31:0] v;
    busWrite(A_COMMIT, 32'h0F);
    busRead(A_COMMIT, v);
    check("R5 commit loads while unlocked", v, 32'h0F);
    busWrite(A_LOCK, 32'h0);
    check("R3 zero relocks", {31'b0, lockedOut}, 32'h1);
    busWrite(A_SELECT, 32'h3C);
    check("R6 low-nibble merge", {24'b0, selOut}, 32'hAC);
    busWrite(A_SELECT, 32'h00);
    check("R6 low-nibble clear", {24'b0, selOut}, 32'hA0);
    busWrite(A_COMMIT, 32'hFF);
    busRead(A_COMMIT, v);
    check("R4 relocked commit unchanged", v, 32'h0F);
  endtask

  task automatic testZeroMask();
    logic [31:0] v;
    busWrite(A_LOCK, KEY);
    busWrite(A_COMMIT, 32'h00);
    busWrite(A_SELECT, 32'hFF);
    check("R6 zero mask freezes select", {24'b0, selOut}, 32'hA0);
    busWrite(A_COMMIT, 32'hFF);
    busRead(A_COMMIT, v);
    check("R5 commit restored while unlocked", v, 32'hFF);
    busWrite(A_LOCK, 32'h5);
    check("R3 arbitrary value relocks", {31'b0, lockedOut}, 32'h1);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    busWrite(A_COMMIT, KEY);
    check("R10 key at commit address keeps lock", {31'b0, lockedOut}, 32'h1);
    busWrite(12'h424, KEY);
    check("R10 key at unmapped address keeps lock", {31'b0, lockedOut}, 32'h1);
    busWrite(12'h000, 32'hFF);
    check("R10 unmapped write keeps select", {24'b0, selOut}, 32'hA0);
    busRead(A_COMMIT, v);
    check("R10 unmapped write keeps commit", v, 32'hFF);
    busRead(12'h400, v);
    check("R8 unmapped read returns zero", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFullMask();
    testLockedCommit();
    testUnlock();
    testPartialMask();
    testZeroMask();
    testUnmapped();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule